// File: doc/BRIEF.md
# IDE Bridge Command Stream Encoder

This block sits on the host side of a byte-oriented USB-to-IDE bridge. It takes one high-level IDE bus request at a time and turns it into the exact run of command bytes that the bridge expects. The bridge keeps a 16-bit parameter register that is loaded four bits at a time by "nibble" bytes. A write therefore becomes a run of nibble bytes, most significant first, followed by one opcode byte. Each opcode byte carries the operation in its upper four bits and a modifier in its lower four. Reads, control updates, status queries and timing setup are single opcode bytes.

Requests arrive on a valid/ready port. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Command bytes leave on a second valid/ready port. A byte is consumed on an edge where `cmd_valid` and `cmd_ready` are both high. While `cmd_ready` is low, the offered byte is held unchanged. While a sequence is still in flight, the block applies back-pressure upstream by holding `req_ready` low. Strobe-width requests outside the 6-bit field are clamped, and this is reported on a one-cycle flag.

Top module: `idecmd_encoder`

## Requirements
- R1: `req_kind` encodes the operation: 0 register write, 1 register read, 2 DMA write, 3 DMA read, 4 control update, 5 status query, 6 timing setup, 7 unused. After reset, `req_ready` is 1 and `cmd_valid` and `timing_err` are 0. A request accepted on one edge with kind 0–6 has its first byte offered (`cmd_valid` high) from the next cycle.
- R2: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and `cmd_byte` does not change on the following cycle.
- R3: A register write with `req_aux`=0 and `req_addr`=0 emits four nibble bytes `0000_dddd` with data bits [15:12], [11:8], [7:4] and [3:0] in that order, then the byte 0x10.
- R4: Any other register write emits two nibble bytes carrying data bits [7:4] and then [3:0], followed by `0001_0AAA` (`req_aux`=0) or `0010_0AAA` (`req_aux`=1), where AAA is `req_addr`. The auxiliary group at address 0 also takes two nibbles.
- R5: A DMA write emits four nibble bytes, most significant nibble first, then 0x30.
- R6: Reads emit exactly one byte and no nibbles: `0101_0AAA` for the primary group, `0110_0AAA` for the auxiliary group, and 0x70 for a DMA read. The request data is ignored.
- R7: A control update emits `0100_0CRA`, where C, R and A are `req_data` bits 2, 1 and 0. A status query emits 0x48.
- R8: A timing setup emits `10_WWWWWW`, where W is `req_data` when that value is between 1 and 63 inclusive. `timing_err` stays 0 for such a request.
- R9: A timing value of 0 is sent as W=1, and a value above 63 is sent as W=63. In both cases `timing_err` is 1 for exactly the cycle after acceptance.
- R10: A request of kind 7 is accepted but emits no byte. `req_ready` is still 1 on the cycle after acceptance.
- R11: `req_ready` is 0 whenever `cmd_valid` is 1. A new request is taken only after the last byte of the current sequence has been consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Encoder can take a request |
| req_kind | input | 3 | Operation code (see R1) |
| req_aux | input | 1 | 0 primary chip-select group, 1 auxiliary group |
| req_addr | input | 3 | Register address |
| req_data | input | 16 | Write data, control bits or strobe width |
| cmd_valid | output | 1 | Command byte offered |
| cmd_ready | input | 1 | Downstream takes the offered byte |
| cmd_byte | output | 8 | Command byte |
| timing_err | output | 1 | One-cycle pulse when a strobe width was clamped |

## Verification
The hardest situation to reach from the ports is a long nibble run that stalls in the middle. In that case the shift state, the remaining count and the upstream `req_ready` must all stay frozen across irregular `cmd_ready` gaps. The bench reaches it by driving `cmd_ready` from a pseudo-random sequence while it replays five-byte register and DMA writes. It checks that every stalled byte is stable and that no second request slips in before the final opcode byte.

// File: rtl/idecmd_pkg.sv
package idecmd_pkg;
  localparam int ADDR_W = 3;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    K_REG_WR = 3'd0,
    K_REG_RD = 3'd1,
    K_DMA_WR = 3'd2,
    K_DMA_RD = 3'd3,
    K_CTRL   = 3'd4,
    K_STATUS = 3'd5,
    K_TIMING = 3'd6,
    K_NONE   = 3'd7
  } req_kind_e;

  // upper-nibble opcodes understood by the bridge
  localparam logic [3:0] OP_WR_PRI = 4'h1;
  localparam logic [3:0] OP_WR_AUX = 4'h2;
  localparam logic [3:0] OP_WR_DMA = 4'h3;
  localparam logic [3:0] OP_CTRL   = 4'h4;
  localparam logic [3:0] OP_RD_PRI = 4'h5;
  localparam logic [3:0] OP_RD_AUX = 4'h6;
  localparam logic [3:0] OP_RD_DMA = 4'h7;
endpackage

// File: rtl/idecmd_clamp.sv
module idecmd_clamp #(
  parameter int DATA_W = 16,
  parameter int TIME_W = 6
) (
  input  logic [DATA_W-1:0] value,
  output logic [TIME_W-1:0] width,
  output logic              clamped
);
  localparam logic [DATA_W-1:0] MAX_W = DATA_W'((1 << TIME_W) - 1);

  always_comb begin
    if (value == '0) begin
      width   = TIME_W'(1);
      clamped = 1'b1;
    end else if (value > MAX_W) begin
      width   = MAX_W[TIME_W-1:0];
      clamped = 1'b1;
    end else begin
      width   = value[TIME_W-1:0];
      clamped = 1'b0;
    end
  end
endmodule

// File: rtl/idecmd_plan.sv
module idecmd_plan
  import idecmd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TIME_W = 6,
  parameter int CNT_W  = 3
) (
  input  req_kind_e            kind,
  input  logic                 aux,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    data,
  output logic                 emits,
  output logic [CNT_W-1:0]     nib_cnt,
  output logic [DATA_W-1:0]    word,
  output logic [BYTE_W-1:0]    opcode,
  output logic                 clamped
);
  localparam int NIB_WORD = DATA_W / NIB_W;
  localparam int NIB_BYTE = BYTE_W / NIB_W;

  logic [TIME_W-1:0] width;

  idecmd_clamp #(.DATA_W(DATA_W), .TIME_W(TIME_W)) u_clamp (
    .value   (data),
    .width   (width),
    .clamped (clamped)
  );

  logic [DATA_W-1:0] low_aligned;
  assign low_aligned = data << (DATA_W - BYTE_W);

  always_comb begin
    emits   = 1'b1;
    nib_cnt = '0;
    word    = '0;
    opcode  = '0;
    unique case (kind)
      K_REG_WR: begin
        opcode = {(aux ? OP_WR_AUX : OP_WR_PRI), 1'b0, addr};
        if (!aux && addr == '0) begin
          nib_cnt = CNT_W'(NIB_WORD);
          word    = data;
        end else begin
          nib_cnt = CNT_W'(NIB_BYTE);
          word    = low_aligned;
        end
      end
      K_DMA_WR: begin
        opcode  = {OP_WR_DMA, 4'h0};
        nib_cnt = CNT_W'(NIB_WORD);
        word    = data;
      end
      K_REG_RD: opcode = {(aux ? OP_RD_AUX : OP_RD_PRI), 1'b0, addr};
      K_DMA_RD: opcode = {OP_RD_DMA, 4'h0};
      K_CTRL:   opcode = {OP_CTRL, 1'b0, data[2:0]};
      K_STATUS: opcode = {OP_CTRL, 4'h8};
      K_TIMING: opcode = {2'b10, width};
      default:  emits  = 1'b0;
    endcase
  end
endmodule

// File: rtl/idecmd_emit.sv
module idecmd_emit
  import idecmd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               start_emits,
  input  logic [CNT_W-1:0]   start_cnt,
  input  logic [DATA_W-1:0]  start_word,
  input  logic [BYTE_W-1:0]  start_op,
  output logic               busy,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [BYTE_W-1:0]  out_byte
);
  logic [CNT_W-1:0]  left_q;
  logic [DATA_W-1:0] shift_q;
  logic [BYTE_W-1:0] op_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      left_q  <= '0;
      shift_q <= '0;
      op_q    <= '0;
    end else if (start) begin
      busy    <= start_emits;
      left_q  <= start_cnt;
      shift_q <= start_word;
      op_q    <= start_op;
    end else if (busy && out_ready) begin
      if (left_q != '0) begin
        left_q  <= left_q - 1'b1;
        shift_q <= shift_q << NIB_W;
      end else begin
        busy <= 1'b0;
      end
    end
  end

  assign out_valid = busy;
  assign out_byte  = (left_q != '0) ? {4'h0, shift_q[DATA_W-1 -: NIB_W]} : op_q;
endmodule

// File: rtl/idecmd_encoder.sv
module idecmd_encoder
  import idecmd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TIME_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic              req_aux,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic              timing_err
);
  localparam int CNT_W = $clog2(DATA_W / NIB_W + 1);

  req_kind_e         kind;
  logic              accept;
  logic              busy;
  logic              p_emits;
  logic [CNT_W-1:0]  p_cnt;
  logic [DATA_W-1:0] p_word;
  logic [BYTE_W-1:0] p_op;
  logic              p_clamped;

  assign kind      = req_kind_e'(req_kind);
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  idecmd_plan #(.DATA_W(DATA_W), .TIME_W(TIME_W), .CNT_W(CNT_W)) u_plan (
    .kind    (kind),
    .aux     (req_aux),
    .addr    (req_addr),
    .data    (req_data),
    .emits   (p_emits),
    .nib_cnt (p_cnt),
    .word    (p_word),
    .opcode  (p_op),
    .clamped (p_clamped)
  );

  idecmd_emit #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_emit (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .start_emits (p_emits),
    .start_cnt   (p_cnt),
    .start_word  (p_word),
    .start_op    (p_op),
    .busy        (busy),
    .out_valid   (cmd_valid),
    .out_ready   (cmd_ready),
    .out_byte    (cmd_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) timing_err <= 1'b0;
    else        timing_err <= accept && (kind == K_TIMING) && p_clamped;
  end
endmodule

// File: rtl/idecmd_encoder_chk.sv
module idecmd_encoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [2:0]  req_kind,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [7:0]  cmd_byte,
  input logic        timing_err
);
  AST_START_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_kind != 3'd7 |=> cmd_valid); // R1
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_byte)); // R2
  AST_TIME_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_byte[7] |-> !cmd_byte[6] && cmd_byte[5:0] != 6'd0); // R8
  AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    timing_err |-> $past(req_valid && req_ready && req_kind == 3'd6)); // R9
  AST_NONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_kind == 3'd7 |=> !cmd_valid && req_ready); // R10
  AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready); // R11
endmodule

bind idecmd_encoder idecmd_encoder_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_kind   (req_kind),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_byte   (cmd_byte),
  .timing_err (timing_err)
);

// File: tb/sim_idecmd_encoder.sv
module sim_idecmd_encoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_kind = 3'd0;
  logic        req_aux = 1'b0;
  logic [2:0]  req_addr = 3'd0;
  logic [15:0] req_data = 16'd0;
  logic        cmd_valid;
  logic        cmd_ready = 1'b1;
  logic [7:0]  cmd_byte;
  logic        timing_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int ncap = 0;
  logic [7:0] cap [0:7];
  logic       stall_on = 1'b0;
  logic [7:0] lfsr = 8'hA7;
  logic       prev_stall = 1'b0;
  logic [7:0] prev_byte = 8'h00;

  always #5 clk = ~clk;

  idecmd_encoder u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_aux(req_aux), .req_addr(req_addr), .req_data(req_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_byte(cmd_byte),
    .timing_err(timing_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // downstream ready driver, changes just after the rising edge
  always @(posedge clk) begin
    #1;
    if (stall_on) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cmd_ready = lfsr[0] | lfsr[3];
    end else begin
      cmd_ready = 1'b1;
    end
  end

  // monitor: sample at the falling edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (prev_stall) begin
        check("R2 valid held", {31'd0, cmd_valid}, 32'd1);
        check("R2 byte held", {24'd0, cmd_byte}, {24'd0, prev_byte});
      end
      if (cmd_valid && req_ready) check("R11 ready while busy", 32'd1, 32'd0);
      if (cmd_valid && cmd_ready) begin
        if (ncap < 8) cap[ncap] = cmd_byte;
        ncap++;
      end
      prev_stall = cmd_valid && !cmd_ready;
      prev_byte  = cmd_byte;
    end
  end

  always @(negedge clk) begin
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // issue one request and compare the emitted bytes (exp packed, first byte on top)
  task automatic run(input string req, input logic [2:0] kind, input logic aux,
                     input logic [2:0] addr, input logic [15:0] data,
                     input int n, input logic [39:0] exp, input logic exp_err);
    @(posedge clk); #1;
    ncap = 0;
    req_kind = kind; req_aux = aux; req_addr = addr; req_data = data;
    req_valid = 1'b1;
    for (int w = 0; w < 50; w++) begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    check({req, " first valid"}, {31'd0, cmd_valid}, (n > 0) ? 32'd1 : 32'd0);
    check({req, " err flag"}, {31'd0, timing_err}, {31'd0, exp_err});
    if (n == 0) check({req, " ready"}, {31'd0, req_ready}, 32'd1);
    for (int w = 0; w < 60; w++) begin
      if (!cmd_valid && req_ready) break;
      @(negedge clk);
    end
    check({req, " err gone"}, {31'd0, timing_err}, 32'd0);
    check({req, " count"}, ncap, n);
    for (int i = 0; i < n && i < 5; i++)
      check({req, " byte"}, {24'd0, cap[i]}, {24'd0, exp[39 - 8*i -: 8]});
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset ready", {31'd0, req_ready}, 32'd1);
    check("R1 reset valid", {31'd0, cmd_valid}, 32'd0);
    check("R1 reset err", {31'd0, timing_err}, 32'd0);
  endtask

  task automatic t_reg_word();
    run("R3 data reg", 3'd0, 1'b0, 3'd0, 16'hA5C3, 5, 40'h0A_05_0C_03_10, 1'b0);
  endtask

  task automatic t_reg_byte();
    run("R4 pri addr3", 3'd0, 1'b0, 3'd3, 16'h12F7, 3, 40'h0F_07_13_00_00, 1'b0);
    run("R4 aux addr6", 3'd0, 1'b1, 3'd6, 16'hBE49, 3, 40'h04_09_26_00_00, 1'b0);
    run("R4 aux addr0", 3'd0, 1'b1, 3'd0, 16'h0081, 3, 40'h08_01_20_00_00, 1'b0);
  endtask

  task automatic t_dma_wr();
    run("R5 dma write", 3'd2, 1'b0, 3'd0, 16'h3E1D, 5, 40'h03_0E_01_0D_30, 1'b0);
  endtask

  task automatic t_reads();
    run("R6 pri read", 3'd1, 1'b0, 3'd5, 16'hFFFF, 1, 40'h55_00_00_00_00, 1'b0);
    run("R6 aux read", 3'd1, 1'b1, 3'd2, 16'h1234, 1, 40'h62_00_00_00_00, 1'b0);
    run("R6 dma read", 3'd3, 1'b1, 3'd7, 16'hFFFF, 1, 40'h70_00_00_00_00, 1'b0);
  endtask

  task automatic t_ctrl();
    run("R7 ctrl 5", 3'd4, 1'b0, 3'd0, 16'hFFF5, 1, 40'h45_00_00_00_00, 1'b0);
    run("R7 ctrl 2", 3'd4, 1'b1, 3'd3, 16'h0002, 1, 40'h42_00_00_00_00, 1'b0);
    run("R7 status", 3'd5, 1'b0, 3'd0, 16'h0007, 1, 40'h48_00_00_00_00, 1'b0);
  endtask

  task automatic t_timing();
    run("R8 width 25", 3'd6, 1'b0, 3'd0, 16'd25, 1, 40'h99_00_00_00_00, 1'b0);
    run("R8 width 63", 3'd6, 1'b0, 3'd0, 16'd63, 1, 40'hBF_00_00_00_00, 1'b0);
    run("R8 width 1", 3'd6, 1'b0, 3'd0, 16'd1, 1, 40'h81_00_00_00_00, 1'b0);
    run("R9 width 0", 3'd6, 1'b0, 3'd0, 16'd0, 1, 40'h81_00_00_00_00, 1'b1);
    run("R9 width 64", 3'd6, 1'b0, 3'd0, 16'd64, 1, 40'hBF_00_00_00_00, 1'b1);
    run("R9 width max", 3'd6, 1'b0, 3'd0, 16'hFFFF, 1, 40'hBF_00_00_00_00, 1'b1);
  endtask

  task automatic t_none();
    run("R10 unused kind", 3'd7, 1'b0, 3'd1, 16'h5555, 0, 40'h0, 1'b0);
  endtask

  task automatic t_stall();
    stall_on = 1'b1;
    run("R2 R11 stalled word", 3'd0, 1'b0, 3'd0, 16'h7B2E, 5, 40'h07_0B_02_0E_10, 1'b0);
    run("R2 R11 stalled dma", 3'd2, 1'b0, 3'd4, 16'hC0DE, 5, 40'h0C_00_0D_0E_30, 1'b0);
    run("R2 stalled byte reg", 3'd0, 1'b1, 3'd1, 16'h00F0, 3, 40'h0F_00_21_00_00, 1'b0);
    stall_on = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_reg_word();
    t_reg_byte();
    t_dma_wr();
    t_reads();
    t_ctrl();
    t_timing();
    t_none();
    t_stall();
    repeat (3) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule